// File: doc/BRIEF.md
# Two-Channel Thermal Level Monitor

This block runs two independent temperature-sensing channels. Each channel takes a per-cycle count of oscillator edges from a front end outside this block. An oscillator that runs faster as the die heats gives a larger count. Timing is kept in reference clock cycles. Every period of M cycles opens a counting window for the first N cycles. When the window closes, the total is latched as the channel's current count and marked valid. The count is then compared against three programmable thresholds to give a thermal level.

The level drives three graded outputs, and each output has its own enable. Level 1 asks software to lower voltage and frequency. Level 2 asks the clock tree to halve the clock. Level 3 raises an emergency reset. A count pinned at full scale is reported as a separate overflow state. When a channel climbs past a threshold whose interrupt is enabled, it sets a sticky pending flag. Software clears that flag by writing a one to it. The shared interrupt line is the OR of the two channels' flags.

Software reaches each channel through a simple single-cycle register bus. Writes are registered. Reads are combinational from the address. The edge inputs are plain sampled data: they are taken every cycle and cannot be held off.

Top module: `thermal_sense_ctrl`

## Requirements
- R1: After reset, the registers read as follows. Configuration (offset 0x00) reads 0. The threshold words read 0xFFFF_FFFF (offset 0x08) and 0x0000_FFFF (offset 0x0C). Status reads 0. While the period field, the window field or the stop bit (bit 0) leaves the channel idle, the valid flag stays 0.
- R2: The configuration word holds the period M in bits 23:8 and the window N in bits 31:24. The latched count equals the sum of the edge input over the first min(N, M) cycles of each M-cycle period. It reads in bits 31:16 of offset 0x1C. Status bit 9 (valid) goes to 1 after the first complete window.
- R3: The count saturates at 0xFFFF and does not wrap. A saturated count reads as state 5 in status bits 2:0.
- R4: Three thresholds set the level. TH1 is bits 15:0 of 0x08, TH2 is bits 31:16 of 0x08, and TH3 is bits 15:0 of 0x0C. The state is the highest level k for which count >= THk, or 0 if there is none. The state is re-evaluated at the end of every window.
- R5: Each output is gated by its own enable bit. dvfs_req follows enable bit 3 and level >= 1. clkdiv_req follows bit 1 and level >= 2. therm_rst follows bit 2 and level >= 3. Overflow counts as above all three thresholds. All three outputs stay low while the count is not valid.
- R6: The pending flag (status bit 8) is set when a new count enters a higher level across a boundary whose interrupt is enabled. Entering level 1 uses bit 3, level 2 uses bit 5, level 3 uses bit 6, and overflow uses bit 4. A falling level sets nothing.
- R7: Writing status with bit 8 set clears the pending flag. Writing status with bit 8 at 0 leaves the flag unchanged. If a new set and a clear land in the same cycle, the set wins.
- R8: Writing the configuration word, or holding the stop bit, clears valid and the level, drops the level outputs, and restarts the period from its first cycle.
- R9: Channel 0 sits at 0x40 and channel 1 at 0x80, with the offsets above. The two channels run independently, and irq is the OR of their pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| osc_edges | input | NCH*EDGE_W | Oscillator edges seen this cycle, EDGE_W bits per channel, channel 0 in the low bits |
| irq | output | 1 | Shared interrupt line |
| dvfs_req | output | NCH | Level 1 voltage/frequency request per channel |
| clkdiv_req | output | NCH | Level 2 clock-halving request per channel |
| therm_rst | output | NCH | Level 3 emergency reset per channel |

## Verification
The edge input is held at several steady rates: zero, 3, 6 and 9 per cycle over a 10-cycle window. These land exactly below TH1, between each pair of thresholds, and above TH3, so each state code and each output gate is separated. A rate far above full scale checks saturation and the overflow code against a plain large count. A window longer than the period checks the clipping rule. Rate changes made without rewriting the configuration show the difference between rising crossings, which set the pending flag, and falling ones, which do not. Running one channel while the other sits idle checks that the channels are independent.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 16;
  localparam int PER_W = 16;
  localparam int WIN_W = 8;
  localparam int OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_CFG  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_THA  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_THB  = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h18;
  localparam logic [OFS_W-1:0] OFS_CNT  = 6'h1C;

  localparam logic [2:0] RANK_OVF  = 3'd4;
  localparam logic [2:0] STATE_OVF = 3'd5;

  typedef struct packed {
    logic [WIN_W-1:0] win;
    logic [PER_W-1:0] per;
    logic             rsvd;
    logic             ie_hot;
    logic             ie_half;
    logic             ie_sat;
    logic             dvfs_en;
    logic             hot_en;
    logic             half_en;
    logic             halt;
  } chan_cfg_t;
endpackage

// File: rtl/tsc_window.sv
module tsc_window
  import tsc_pkg::*;
#(
  parameter int EDGE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                run,
  input  logic [PER_W-1:0]    per,
  input  logic [WIN_W-1:0]    win,
  input  logic [EDGE_W-1:0]   edges,
  output logic                done,
  output logic [CNT_W-1:0]    sample
);
  localparam int PAD_W = CNT_W + 1 - EDGE_W;

  logic [PER_W-1:0] phase_q;
  logic [CNT_W-1:0] acc_q;
  logic [PER_W-1:0] win_ext, eff_win;
  logic [CNT_W:0]   sum_w;
  logic             in_win;

  assign win_ext = {{(PER_W-WIN_W){1'b0}}, win};
  assign eff_win = (win_ext > per) ? per : win_ext;
  assign in_win  = phase_q < eff_win;
  assign sum_w   = {1'b0, acc_q} + {{PAD_W{1'b0}}, edges};
  assign sample  = sum_w[CNT_W] ? {CNT_W{1'b1}} : sum_w[CNT_W-1:0];
  assign done    = run && (phase_q == eff_win - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (restart || !run) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else begin
      phase_q <= (phase_q == per - 1'b1) ? '0 : phase_q + 1'b1;
      if (done)
        acc_q <= '0;
      else if (in_win)
        acc_q <= sample;
    end
  end
endmodule

// File: rtl/tsc_level.sv
module tsc_level
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             done,
  input  logic [CNT_W-1:0] sample,
  input  logic [CNT_W-1:0] th1,
  input  logic [CNT_W-1:0] th2,
  input  logic [CNT_W-1:0] th3,
  input  chan_cfg_t        cfg,
  input  logic             pend_clr,
  output logic             valid,
  output logic [2:0]       rank,
  output logic             pend,
  output logic [CNT_W-1:0] count,
  output logic             lvl1_out,
  output logic             lvl2_out,
  output logic             lvl3_out
);
  logic [2:0] new_rank;
  logic       cross1, cross2, cross3, cross_sat, raise;

  always_comb begin
    if (sample == {CNT_W{1'b1}}) new_rank = RANK_OVF;
    else if (sample >= th3)      new_rank = 3'd3;
    else if (sample >= th2)      new_rank = 3'd2;
    else if (sample >= th1)      new_rank = 3'd1;
    else                         new_rank = 3'd0;
  end

  assign cross1    = (rank < 3'd1) && (new_rank >= 3'd1) && cfg.dvfs_en;
  assign cross2    = (rank < 3'd2) && (new_rank >= 3'd2) && cfg.ie_half;
  assign cross3    = (rank < 3'd3) && (new_rank >= 3'd3) && cfg.ie_hot;
  assign cross_sat = (rank != RANK_OVF) && (new_rank == RANK_OVF) && cfg.ie_sat;
  assign raise     = done && !clear && (cross1 || cross2 || cross3 || cross_sat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rank  <= 3'd0;
      count <= '0;
    end else if (clear) begin
      valid <= 1'b0;
      rank  <= 3'd0;
      count <= '0;
    end else if (done) begin
      valid <= 1'b1;
      rank  <= new_rank;
      count <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (raise)    pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  assign lvl1_out = valid && cfg.dvfs_en && (rank >= 3'd1);
  assign lvl2_out = valid && cfg.half_en && (rank >= 3'd2);
  assign lvl3_out = valid && cfg.hot_en  && (rank >= 3'd3);
endmodule

// File: rtl/tsc_channel.sv
module tsc_channel
  import tsc_pkg::*;
#(
  parameter int EDGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [EDGE_W-1:0] edges,
  output logic              valid,
  output logic [2:0]        rank,
  output logic              pend,
  output logic              cfg_wr,
  output logic              lvl1_out,
  output logic              lvl2_out,
  output logic              lvl3_out
);
  chan_cfg_t        cfg_q;
  logic [REG_W-1:0] tha_q;
  logic [CNT_W-1:0] thb_q;
  logic             run, done, pend_clr;
  logic [CNT_W-1:0] sample, count;
  logic [2:0]       state;

  assign cfg_wr   = wr_en && (ofs == OFS_CFG);
  assign pend_clr = wr_en && (ofs == OFS_STAT) && wdata[8];
  assign run      = !cfg_q.halt && (cfg_q.per != '0) && (cfg_q.win != '0);
  assign state    = (rank == RANK_OVF) ? STATE_OVF : rank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tha_q <= '1;
      thb_q <= '1;
    end else if (wr_en) begin
      if (ofs == OFS_CFG) cfg_q <= chan_cfg_t'(wdata);
      if (ofs == OFS_THA) tha_q <= wdata;
      if (ofs == OFS_THB) thb_q <= wdata[CNT_W-1:0];
    end
  end

  tsc_window #(.EDGE_W(EDGE_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .run     (run),
    .per     (cfg_q.per),
    .win     (cfg_q.win),
    .edges   (edges),
    .done    (done),
    .sample  (sample)
  );

  tsc_level u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_wr || !run),
    .done     (done),
    .sample   (sample),
    .th1      (tha_q[CNT_W-1:0]),
    .th2      (tha_q[2*CNT_W-1:CNT_W]),
    .th3      (thb_q),
    .cfg      (cfg_q),
    .pend_clr (pend_clr),
    .valid    (valid),
    .rank     (rank),
    .pend     (pend),
    .count    (count),
    .lvl1_out (lvl1_out),
    .lvl2_out (lvl2_out),
    .lvl3_out (lvl3_out)
  );

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_CFG:  rdata = cfg_q;
      OFS_THA:  rdata = tha_q;
      OFS_THB:  rdata = {{(REG_W-CNT_W){1'b0}}, thb_q};
      OFS_STAT: begin
        rdata[2:0] = state;
        rdata[8]   = pend;
        rdata[9]   = valid;
      end
      OFS_CNT:  rdata[REG_W-1:REG_W-CNT_W] = count;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/thermal_sense_ctrl.sv
module thermal_sense_ctrl
  import tsc_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int EDGE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [NCH*EDGE_W-1:0] osc_edges,
  output logic                  irq,
  output logic [NCH-1:0]        dvfs_req,
  output logic [NCH-1:0]        clkdiv_req,
  output logic [NCH-1:0]        therm_rst
);
  localparam int BLK_W = ADDR_W - OFS_W;

  logic [BLK_W-1:0] blk;
  logic [NCH-1:0]   ch_sel, ch_valid, ch_pend, cfg_wr;
  logic [NCH*3-1:0] ch_rank_flat;
  logic [REG_W-1:0] ch_rdata [NCH];

  assign blk = bus_addr[ADDR_W-1:OFS_W];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i] = (blk == BLK_W'(i + 1));

    tsc_channel #(.EDGE_W(EDGE_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && ch_sel[i]),
      .ofs      (bus_addr[OFS_W-1:0]),
      .wdata    (bus_wdata),
      .rdata    (ch_rdata[i]),
      .edges    (osc_edges[i*EDGE_W +: EDGE_W]),
      .valid    (ch_valid[i]),
      .rank     (ch_rank_flat[i*3 +: 3]),
      .pend     (ch_pend[i]),
      .cfg_wr   (cfg_wr[i]),
      .lvl1_out (dvfs_req[i]),
      .lvl2_out (clkdiv_req[i]),
      .lvl3_out (therm_rst[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (ch_sel[i]) bus_rdata = ch_rdata[i];
  end

  assign irq = |ch_pend;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [NCH-1:0] dvfs_req,
  input logic [NCH-1:0] clkdiv_req,
  input logic [NCH-1:0] therm_rst,
  input logic [NCH-1:0] ch_valid,
  input logic [NCH-1:0] ch_pend,
  input logic [NCH-1:0] cfg_wr,
  input logic [NCH*3-1:0] ch_rank_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dvfs_req[i] || clkdiv_req[i] || therm_rst[i]) |-> ch_valid[i]);

    p_rst_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      therm_rst[i] |-> (ch_rank_flat[i*3 +: 3] >= 3'd3));

    p_rank_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rank_flat[i*3 +: 3] <= 3'd4);

    p_cfg_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr[i] |=> !ch_valid[i]);

    p_pend_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_pend[i]) |-> $past(bus_wr));

    p_pend_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_pend[i]) |-> ch_valid[i]);
  end
endmodule

bind thermal_sense_ctrl tsc_checker #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .dvfs_req     (dvfs_req),
  .clkdiv_req   (clkdiv_req),
  .therm_rst    (therm_rst),
  .ch_valid     (ch_valid),
  .ch_pend      (ch_pend),
  .cfg_wr       (cfg_wr),
  .ch_rank_flat (ch_rank_flat)
);

// File: tb/thermal_sense_ctrl_test.sv
module thermal_sense_ctrl_test;
  localparam int NCH = 2;
  localparam int EDGE_W = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [EDGE_W-1:0] inc0 = '0, inc1 = '0;
  logic        irq;
  logic [NCH-1:0] dvfs_req, clkdiv_req, therm_rst;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int          ch;
    logic [15:0] cnt;
    logic [2:0]  st;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  thermal_sense_ctrl #(.NCH(NCH), .ADDR_W(8), .EDGE_W(EDGE_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .osc_edges  ({inc1, inc0}),
    .irq        (irq),
    .dvfs_req   (dvfs_req),
    .clkdiv_req (clkdiv_req),
    .therm_rst  (therm_rst)
  );

  function automatic logic [7:0] base(int ch);
    return 8'h40 * (ch + 1);
  endfunction

  function automatic logic [31:0] cfgw(int win, int per, logic [7:0] en);
    return (32'(win) << 24) | (32'(per) << 8) | 32'(en);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push_exp(int ch, logic [15:0] cnt, logic [2:0] st, string tag);
    exp_t e;
    e.ch = ch; e.cnt = cnt; e.st = st; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic monitor_pop();
    exp_t e;
    logic [31:0] s, c;
    int tries;
    e = sbq.pop_front();
    tries = 0;
    s = '0;
    while (!s[9] && tries < 400) begin
      rd(base(e.ch) + 8'h18, s);
      tries++;
    end
    rd(base(e.ch) + 8'h1C, c);
    chk({e.tag, " count"}, 32'(c[31:16]), 32'(e.cnt));
    chk({e.tag, " state"}, 32'(s[2:0]), 32'(e.st));
  endtask

  task automatic outs(string tag, logic [5:0] exp);
    @(negedge clk);
    #1 chk(tag, 32'({dvfs_req, clkdiv_req, therm_rst}), 32'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h40, d); chk("R1 cfg reset", d, 32'h0);
    rd(8'h48, d); chk("R1 tha reset", d, 32'hFFFF_FFFF);
    rd(8'h4C, d); chk("R1 thb reset", d, 32'h0000_FFFF);
    rd(8'h58, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R1 no measurement while unprogrammed
    inc0 = 10'd5; inc1 = 10'd5;
    repeat (40) @(negedge clk);
    rd(8'h58, d); chk("R1 idle valid", 32'(d[9]), 32'h0);

    // thresholds 25 / 50 / 80 on both channels
    wr(8'h48, {16'd50, 16'd25}); wr(8'h4C, 32'd80);
    wr(8'h88, {16'd50, 16'd25}); wr(8'h8C, 32'd80);

    // R2 / R4 level 1 on channel 0
    inc0 = 10'd3;
    wr(8'h40, cfgw(10, 16, 8'h7E));
    push_exp(0, 16'd30, 3'd1, "R2 R4 lvl1");
    monitor_pop();
    outs("R5 lvl1 outputs", 6'b01_00_00);
    chk("R6 irq rising lvl1", 32'(irq), 32'h1);
    rd(8'h98, d); chk("R9 ch1 idle", d, 32'h0);

    // R7 write-one-to-clear
    wr(8'h58, 32'h0);
    rd(8'h58, d); chk("R7 zero write keeps", 32'(d[8]), 32'h1);
    wr(8'h58, 32'h100);
    rd(8'h58, d); chk("R7 one write clears", 32'(d[8]), 32'h0);
    chk("R7 irq low", 32'(irq), 32'h0);

    // R4 / R6 rise to level 3 without restart
    inc0 = 10'd9;
    repeat (60) @(negedge clk);
    push_exp(0, 16'd90, 3'd3, "R4 lvl3");
    monitor_pop();
    outs("R5 lvl3 outputs", 6'b01_01_01);
    rd(8'h58, d); chk("R6 pend lvl3", 32'(d[8]), 32'h1);
    wr(8'h58, 32'h100);

    // R6 falling gives no interrupt
    inc0 = 10'd0;
    repeat (60) @(negedge clk);
    push_exp(0, 16'd0, 3'd0, "R4 lvl0");
    monitor_pop();
    rd(8'h58, d); chk("R6 falling no pend", 32'(d[8]), 32'h0);
    outs("R5 lvl0 outputs", 6'b00_00_00);

    // R8 stop bit
    inc0 = 10'd9;
    wr(8'h40, cfgw(10, 16, 8'h7F));
    rd(8'h58, d); chk("R8 stop clears", d, 32'h0);
    repeat (40) @(negedge clk);
    rd(8'h58, d); chk("R1 stopped stays invalid", 32'(d[9]), 32'h0);
    outs("R8 outputs low", 6'b00_00_00);

    // R9 / R5 channel 1 level 2, dvfs enable off
    inc1 = 10'd6;
    wr(8'h80, cfgw(10, 16, 8'h76));
    push_exp(1, 16'd60, 3'd2, "R9 ch1 lvl2");
    monitor_pop();
    outs("R5 ch1 gated dvfs", 6'b00_10_00);
    rd(8'h98, d); chk("R6 pend lvl2", 32'(d[8]), 32'h1);
    chk("R9 irq from ch1", 32'(irq), 32'h1);

    // R3 overflow on channel 0
    inc0 = 10'd1000;
    wr(8'h40, cfgw(70, 80, 8'h7E));
    push_exp(0, 16'hFFFF, 3'd5, "R3 overflow");
    monitor_pop();
    @(negedge clk); #1 chk("R3 ovf therm_rst", 32'(therm_rst[0]), 32'h1);
    rd(8'h58, d); chk("R6 pend ovf", 32'(d[8]), 32'h1);
    wr(8'h58, 32'h100);

    // R2 window clipped to period
    inc0 = 10'd2;
    wr(8'h40, cfgw(20, 8, 8'h7E));
    push_exp(0, 16'd16, 3'd0, "R2 clipped window");
    monitor_pop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule